// File: doc/BRIEF.md
# Receive Record FIFO

This block accepts received frames as a byte stream and stores each one in a byte-wide FIFO as a self-describing record. A record starts with a fixed marker word and an information word that holds the stored length and a good-status code. The frame data follows, zero-filled up to the minimum frame size, then a CRC-32 word over data and fill, then zero bytes up to the next 4-byte boundary. Frame data is written ahead of its header. The trailer and then the header are written once the last byte has arrived, and only then is the record made visible.

A 32-bit read port hands the records back word by word. The reader follows its position within the current record and uses the length field of the information word to find where the record ends. A counter reports how many whole records are held. Each stored record raises an interrupt flag that stays set until it is acknowledged. A frame is discarded whole if reception is disabled or if the record would not fit in the free space.

Top module: `rx_record_fifo`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `pkt_count` is 0, `rx_irq` is 0 and `in_ready` is 0.
- R2: `in_ready` is high, one cycle after the fact, exactly when `rx_en` is high, at least READY_MIN (1532) bytes are free, and the writer is waiting for frame bytes.
- R3: A stored record reads back as the marker word MAGIC, then the information word, then the frame bytes, fill, CRC bytes and zero bytes up to a multiple of 4. Record byte k appears in bits 8*(k mod 4)+7 down to 8*(k mod 4) of read word k/4, so the lowest-numbered byte is least significant.
- R4: A frame shorter than MIN_FRAME (60) bytes is followed by zero bytes up to MIN_FRAME bytes.
- R5: Bits 15:0 of the information word hold the filled size plus 4. Bits 31:16 hold OK_CODE (0x0001).
- R6: The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and is complemented at the end. It covers the frame bytes and the fill, and it is stored least significant byte first right after them.
- R7: A frame that has any byte arrive while `rx_en` is low is discarded. `pkt_count` and `rx_irq` do not change, and nothing of it can be read.
- R8: A frame whose record would need more bytes than are free is discarded. Occupancy never exceeds DEPTH.
- R9: Each stored record increments `pkt_count` and sets `rx_irq`. `irq_ack` clears `rx_irq`, and a new record in the same cycle as `irq_ack` leaves it set.
- R10: After the word that carries the last byte of a record is read, `pkt_count` decrements and the next read returns the next record's marker word.
- R11: A read while `pkt_count` is 0 returns 0 and removes nothing from the FIFO.
- R12: `rd_valid` is high, and `rd_data` holds the word, in the cycle after `rd_req`. Reads may be issued every cycle.
- R13: If a record is stored in the same cycle as the last word of another record is read, `pkt_count` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Reception enable |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_ready | output | 1 | Room for a maximum-size frame and writer waiting |
| rd_req | input | 1 | Read one word |
| rd_data | output | 32 | Word read, valid with rd_valid |
| rd_valid | output | 1 | rd_data holds the word requested last cycle |
| pkt_count | output | $clog2(DEPTH) | Whole records stored |
| irq_ack | input | 1 | Clear the receive interrupt flag |
| rx_irq | output | 1 | Receive interrupt flag |

## Verification
Storing a new record and reading out the last word of an older record both change the packet counter, and they can land on the same clock edge. The bench leaves one word of a stored record unread and then sends a 60-byte frame. It counts the fixed trailer and header write cycles from the frame's last byte and issues the final read, together with an interrupt acknowledge, so that it is sampled on the commit edge. The test passes if the counter holds its value across that edge, the interrupt flag stays set, and the word queue for both records matches.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [1:0] {W_DATA, W_TRAIL, W_HDR} wr_state_e;
  typedef enum logic [1:0] {P_MAGIC, P_INFO, P_BODY} rd_phase_e;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rxr_lane_ram.sv
module rxr_lane_ram #(
  parameter int DEPTH = 2048
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [7:0]             wdata,
  input  logic [$clog2(DEPTH)-3:0] raddr,
  output logic [31:0]            rdata
);
  localparam int AW    = $clog2(DEPTH);
  localparam int WORDS = DEPTH / 4;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] mem [WORDS];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (we && (waddr[1:0] == 2'(g))) mem[waddr[AW-1:2]] <= wdata;
    end
    always_ff @(posedge clk) begin
      q <= mem[raddr];
    end
    assign rdata[8*g +: 8] = q;
  end

endmodule

// File: rtl/rxr_writer.sv
module rxr_writer
  import rxr_pkg::*;
#(
  parameter int          DEPTH     = 2048,
  parameter int          READY_MIN = 1532,
  parameter int          MIN_FRAME = 60,
  parameter logic [31:0] MAGIC     = 32'h0143_4F52,
  parameter logic [15:0] OK_CODE   = 16'h0001
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rx_en,
  input  logic                     in_valid,
  input  logic [7:0]               in_data,
  input  logic                     in_last,
  input  logic [$clog2(DEPTH):0]   free,
  output logic                     in_ready,
  output logic [$clog2(DEPTH):0]   wbase,
  output logic                     we,
  output logic [$clog2(DEPTH)-1:0] waddr,
  output logic [7:0]               wdata,
  output logic                     commit
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  wr_state_e   st;
  logic [15:0] n, idx, padded, total;
  logic        keep, skip;
  logic [31:0] crc;

  logic [16:0] free_x;
  logic        room, accept, keep_nx, fits;
  logic [15:0] n_nx, pad_nx, tot_nx, off;
  logic [31:0] crc_nx, crc_fin, info_word;
  logic [7:0]  trail_byte, head_byte;
  logic [PW-1:0] wptr;

  always_comb begin
    free_x    = 17'(free);
    room      = ({1'b0, n} + 17'd9) <= free_x;
    accept    = in_valid && !skip && (st == W_DATA) && keep && rx_en && room;
    keep_nx   = keep && rx_en && room;
    n_nx      = accept ? n + 16'd1 : n;
    pad_nx    = (n_nx < 16'(MIN_FRAME)) ? 16'(MIN_FRAME) : n_nx;
    tot_nx    = (pad_nx + 16'd15) & ~16'd3;
    fits      = {1'b0, tot_nx} <= free_x;
    crc_nx    = accept ? crc32_step(crc, in_data) : crc;
    crc_fin   = ~crc;
    off       = idx - padded;
    info_word = {OK_CODE, padded + 16'd4};
    if (idx < padded)               trail_byte = 8'd0;
    else if (idx < padded + 16'd4)  trail_byte = crc_fin[8*off[1:0] +: 8];
    else                            trail_byte = 8'd0;
    head_byte = idx[2] ? info_word[8*idx[1:0] +: 8] : MAGIC[8*idx[1:0] +: 8];
  end

  always_comb begin
    we     = 1'b0;
    wdata  = 8'd0;
    wptr   = wbase;
    commit = 1'b0;
    unique case (st)
      W_DATA:  begin we = accept; wdata = in_data;    wptr = wbase + PW'(8) + PW'(n);   end
      W_TRAIL: begin we = 1'b1;   wdata = trail_byte; wptr = wbase + PW'(8) + PW'(idx); end
      W_HDR:   begin we = 1'b1;   wdata = head_byte;  wptr = wbase + PW'(idx);
                     commit = (idx == 16'd7); end
      default: ;
    endcase
    waddr = wptr[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= W_DATA; wbase <= '0; n <= '0; idx <= '0; padded <= '0; total <= '0;
      keep <= 1'b1; skip <= 1'b0; crc <= '1; in_ready <= 1'b0;
    end else begin
      in_ready <= rx_en && (free >= PW'(READY_MIN)) && (st == W_DATA);
      unique case (st)
        W_DATA: if (in_valid) begin
          if (skip) begin
            if (in_last) skip <= 1'b0;
          end else begin
            n <= n_nx; keep <= keep_nx; crc <= crc_nx;
            if (in_last) begin
              if (keep_nx && fits) begin
                st <= W_TRAIL; padded <= pad_nx; total <= tot_nx; idx <= n_nx;
              end else begin
                n <= '0; keep <= 1'b1; crc <= '1;
              end
            end
          end
        end
        W_TRAIL: begin
          if (idx < padded) crc <= crc32_step(crc, 8'd0);
          idx <= idx + 16'd1;
          if (idx + 16'd9 == total) begin st <= W_HDR; idx <= '0; end
        end
        W_HDR: begin
          idx <= idx + 16'd1;
          if (idx == 16'd7) begin
            st <= W_DATA; wbase <= wbase + PW'(total);
            n <= '0; keep <= 1'b1; crc <= '1; idx <= '0;
          end
        end
        default: st <= W_DATA;
      endcase
      if (st != W_DATA && in_valid && !in_last) skip <= 1'b1;
    end
  end

  // R2
  ready_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> $past(rx_en));
  // R8
  room_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (st != W_DATA) |-> ({1'b0, total} <= 17'(free)));

endmodule

// File: rtl/rxr_reader.sv
module rxr_reader
  import rxr_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_req,
  input  logic                     commit,
  input  logic [31:0]              ram_q,
  output logic [$clog2(DEPTH)-3:0] raddr,
  output logic [$clog2(DEPTH):0]   rptr,
  output logic [31:0]              rd_data,
  output logic                     rd_valid,
  output logic [$clog2(DEPTH)-1:0] pkt_count
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int CW = AW;

  rd_phase_e   phase;
  logic [15:0] rem, rem_eff;
  logic        info_q, zero_q, have, pop, dec;

  always_comb begin
    rem_eff = info_q ? ((ram_q[15:0] + 16'd3) & ~16'd3) : rem;
    have    = pkt_count != '0;
    pop     = rd_req && have;
    dec     = pop && (phase == P_BODY) && (rem_eff == 16'd4);
    raddr   = rptr[AW-1:2];
    rd_data = zero_q ? 32'd0 : ram_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr <= '0; phase <= P_MAGIC; rem <= '0; info_q <= 1'b0;
      zero_q <= 1'b0; rd_valid <= 1'b0; pkt_count <= '0;
    end else begin
      rd_valid  <= rd_req;
      zero_q    <= rd_req && !have;
      info_q    <= pop && (phase == P_INFO);
      pkt_count <= pkt_count + CW'(commit) - CW'(dec);
      if (info_q) rem <= rem_eff;
      if (pop) begin
        rptr <= rptr + PW'(4);
        unique case (phase)
          P_MAGIC: phase <= P_INFO;
          P_INFO:  phase <= P_BODY;
          P_BODY:  if (rem_eff == 16'd4) phase <= P_MAGIC;
                   else rem <= rem_eff - 16'd4;
          default: phase <= P_MAGIC;
        endcase
      end
    end
  end

  // R11
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && pkt_count == '0) |=> (rptr == $past(rptr)));
  // R10
  body_has_pkt_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == P_BODY) |-> (pkt_count != '0));

endmodule

// File: rtl/rx_record_fifo.sv
module rx_record_fifo #(
  parameter int          DEPTH     = 2048,
  parameter int          READY_MIN = 1532,
  parameter int          MIN_FRAME = 60,
  parameter logic [31:0] MAGIC     = 32'h0143_4F52,
  parameter logic [15:0] OK_CODE   = 16'h0001
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rx_en,
  input  logic                     in_valid,
  input  logic [7:0]               in_data,
  input  logic                     in_last,
  output logic                     in_ready,
  input  logic                     rd_req,
  output logic [31:0]              rd_data,
  output logic                     rd_valid,
  output logic [$clog2(DEPTH)-1:0] pkt_count,
  input  logic                     irq_ack,
  output logic                     rx_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wbase, rptr, used, free;
  logic          we, commit;
  logic [AW-1:0] waddr;
  logic [7:0]    wdata;
  logic [AW-3:0] raddr;
  logic [31:0]   ram_q;

  assign used = wbase - rptr;
  assign free = PW'(DEPTH) - used;

  rxr_writer #(.DEPTH(DEPTH), .READY_MIN(READY_MIN), .MIN_FRAME(MIN_FRAME),
               .MAGIC(MAGIC), .OK_CODE(OK_CODE)) u_wr (
    .clk, .rst, .rx_en, .in_valid, .in_data, .in_last, .free,
    .in_ready, .wbase, .we, .waddr, .wdata, .commit);

  rxr_lane_ram #(.DEPTH(DEPTH)) u_ram (
    .clk, .we, .waddr, .wdata, .raddr, .rdata(ram_q));

  rxr_reader #(.DEPTH(DEPTH)) u_rd (
    .clk, .rst, .rd_req, .commit, .ram_q, .raddr, .rptr,
    .rd_data, .rd_valid, .pkt_count);

  always_ff @(posedge clk) begin
    if (rst)          rx_irq <= 1'b0;
    else if (commit)  rx_irq <= 1'b1;
    else if (irq_ack) rx_irq <= 1'b0;
  end

  // R9
  irq_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> rx_irq);
  // R8
  occupancy_chk: assert property (@(posedge clk) disable iff (rst)
    used <= PW'(DEPTH));

endmodule

// File: tb/rx_record_fifo_tb.sv
module rx_record_fifo_tb;
  localparam logic [31:0] MAGIC = 32'h0143_4F52;
  localparam int CW = 11;

  logic clk = 1'b0;
  logic rst = 1'b1, rx_en = 1'b1, in_valid = 1'b0, in_last = 1'b0;
  logic rd_req = 1'b0, irq_ack = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic in_ready, rd_valid, rx_irq;
  logic [31:0] rd_data;
  logic [CW-1:0] pkt_count;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  rx_record_fifo u_dut (.clk, .rst, .rx_en, .in_valid, .in_data, .in_last, .in_ready,
    .rd_req, .rd_data, .rd_valid, .pkt_count, .irq_ack, .rx_irq);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check("R12 unexpected word", rd_data, 32'hxxxx_xxxx);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  // driver: build record, queue expected words, drive bytes
  task automatic send_frame(int len, int seed, bit stored, bit settle);
    logic [7:0] rec[$];
    logic [31:0] c = '1, info;
    int padded = (len < 60) ? 60 : len;
    info = {16'h0001, 16'(padded + 4)};
    for (int i = 0; i < 4; i++) rec.push_back(MAGIC[8*i +: 8]);
    for (int i = 0; i < 4; i++) rec.push_back(info[8*i +: 8]);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b = 8'(seed + i * 7);
      rec.push_back(b); c = ref_crc(c, b);
    end
    for (int i = len; i < padded; i++) begin rec.push_back(8'd0); c = ref_crc(c, 8'd0); end
    c = ~c;
    for (int i = 0; i < 4; i++) rec.push_back(c[8*i +: 8]);
    while (rec.size() % 4 != 0) rec.push_back(8'd0);
    if (stored) begin
      for (int w = 0; w < rec.size() / 4; w++) begin
        int lo = 4 * w;
        exp_q.push_back({rec[lo+3], rec[lo+2], rec[lo+1], rec[lo]});
        if (w == 0) tag_q.push_back("R3 marker word");
        else if (w == 1) tag_q.push_back("R5 info word");
        else if (lo + 3 >= 8 + padded && lo < 12 + padded) tag_q.push_back("R6 crc word");
        else if (lo >= 8 + len && lo + 3 < 8 + padded) tag_q.push_back("R4 fill word");
        else tag_q.push_back("R3 data word");
      end
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'(seed + i * 7); in_last = (i == len - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    if (settle) repeat (80) @(negedge clk);
  endtask

  task automatic read_words(int n);
    @(negedge clk);
    rd_req = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic empty_read();
    exp_q.push_back(32'd0); tag_q.push_back("R11 empty read");
    read_words(1);
  endtask

  task automatic ack_irq();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 count in reset", 32'(pkt_count), 0);
    check("R1 irq in reset", 32'(rx_irq), 0);
    check("R1 ready in reset", 32'(in_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 count after reset", 32'(pkt_count), 0);
    repeat (2) @(negedge clk);
    check("R2 ready when enabled and empty", 32'(in_ready), 1);

    empty_read();
    check("R11 count after empty read", 32'(pkt_count), 0);

    send_frame(20, 3, 1, 1);
    check("R9 count after short frame", 32'(pkt_count), 1);
    check("R9 irq after store", 32'(rx_irq), 1);
    read_words(18);
    check("R10 count after record read", 32'(pkt_count), 0);
    ack_irq();
    check("R9 irq cleared by ack", 32'(rx_irq), 0);

    send_frame(61, 40, 1, 1);
    send_frame(64, 90, 1, 1);
    check("R9 two records stored", 32'(pkt_count), 2);
    read_words(38);
    check("R10 both records read back to back", 32'(pkt_count), 0);
    empty_read();
    ack_irq();

    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 ready low when disabled", 32'(in_ready), 0);
    send_frame(30, 7, 0, 1);
    check("R7 count unchanged when disabled", 32'(pkt_count), 0);
    check("R7 irq unchanged when disabled", 32'(rx_irq), 0);
    empty_read();
    rx_en = 1'b1;

    // R13: commit and final-word read on the same edge
    send_frame(60, 11, 1, 1);
    ack_irq();
    read_words(17);
    check("R13 one record pending", 32'(pkt_count), 1);
    send_frame(60, 55, 1, 0);
    repeat (11) @(negedge clk);
    check("R13 count before commit edge", 32'(pkt_count), 1);
    check("R9 irq clear before commit edge", 32'(rx_irq), 0);
    rd_req = 1'b1; irq_ack = 1'b1;
    @(negedge clk);
    rd_req = 1'b0; irq_ack = 1'b0;
    check("R13 count held on coincident edge", 32'(pkt_count), 1);
    check("R9 store wins over ack", 32'(rx_irq), 1);
    @(negedge clk);
    read_words(18);
    check("R10 count after second record", 32'(pkt_count), 0);
    ack_irq();

    send_frame(1400, 9, 1, 1);
    check("R2 ready low when space short", 32'(in_ready), 0);
    send_frame(700, 21, 0, 1);
    check("R8 oversized record dropped", 32'(pkt_count), 1);
    send_frame(600, 33, 1, 1);
    check("R8 fitting record stored", 32'(pkt_count), 2);
    read_words(353 + 153);
    check("R10 all records drained", 32'(pkt_count), 0);
    empty_read();
    repeat (3) @(negedge clk);
    check("R2 ready after drain", 32'(in_ready), 1);
    check("R12 scoreboard drained", 32'(exp_q.size()), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule